// File: doc/BRIEF.md
# Timed Write-Combining Buffer

This block sits between a processor store port and a 32-bit memory or device write port. Stores that target the same aligned word are gathered into one buffer entry. The entry holds four byte lanes, and each lane has its own occupied flag. Partial words are not written at once. The block holds the entry so that later bytes can merge into it, and then issues a single masked write. That write carries a byte strobe covering only the lanes that were filled.

An entry leaves the buffer in one of four ways:
- all four lanes become occupied;
- a countdown of `TIMEOUT` clock cycles runs out;
- a store arrives for a different word;
- a barrier is requested.

The write does not record the order in which individual bytes arrived. Software driving an order-sensitive device must place barriers between the writes whose order matters. The barrier handshake completes only when no buffered or outstanding write remains.

Top module: `store_merge_buf`

## Requirements
- R1: After reset, `mem_valid` is 0, the buffer is empty and `st_ready` is 1.
- R2: An accepted store with byte enables `st_be` (bit i = byte i = `st_data[8i+7:8i]`) to word `st_addr[ADDR_W-1:2]` merges into an entry for the same word. A later write for that entry uses `mem_addr = {word, 2'b00}`, sets `mem_strb` bit i for every occupied lane, and places each lane's byte at `mem_data[8i+7:8i]`. Address bits [1:0] of a store are ignored.
- R3: When an accepted store makes all four lanes occupied, and the write port is free, `mem_valid` rises at the next clock edge with `mem_strb = 4'hF`. The block does not wait for the timer.
- R4: A partial entry opened by a store accepted at edge k is written at edge k+`TIMEOUT`, provided the write port is free. Later merges into the entry do not restart the count.
- R5: A store to a lane that is already occupied replaces that lane's byte, and it does not restart the timer.
- R6: An accepted store to a different word while an entry is held writes out the old entry (its own address, strobe and data) at the next edge. The new store then opens a fresh entry with its timer at zero.
- R7: While `bar_req` is 1 and an entry is held, the entry is written at the next edge the write port is free. Only the occupied lanes are strobed.
- R8: `bar_done` is 1 exactly while `bar_req` is 1, the buffer is empty and no write is outstanding. It is therefore immediate for an empty buffer, and one cycle after the flush write is taken. `st_ready` is 0 while `bar_req` is 1.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr`, `mem_data` and `mem_strb` hold their values and `st_ready` is 0.
- R10: Bytes of one word that arrive out of lane order (for example lanes 0, 2, 1, 3) produce the same single full-word write as bytes that arrive in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted this cycle when valid |
| st_addr | input | ADDR_W | Store byte address; bits [1:0] ignored |
| st_be | input | 4 | Store byte enables, one per lane; nonzero |
| st_data | input | 32 | Store data, byte i in bits [8i+7:8i] |
| bar_req | input | 1 | Barrier request, held until `bar_done` |
| bar_done | output | 1 | Barrier complete |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Write port accepts the request |
| mem_addr | output | ADDR_W | Word-aligned write address |
| mem_strb | output | 4 | Byte lane strobe |
| mem_data | output | 32 | Write data |

## Verification
The assertions rely on a few input rules:
- every store carries at least one byte enable;
- `bar_req`, once raised, is held until `bar_done`;
- the write port may stall for any number of cycles, but it never sees the request withdrawn.

The stimulus keeps to these rules by construction. Store tasks always drive a nonzero `st_be`. The barrier task loops on `bar_done` before dropping the request. Backpressure is applied only through `mem_ready`, so the write-request signals are never manipulated by the bench.

// File: rtl/store_merge_buf.sv
module store_merge_buf #(
  parameter int ADDR_W  = 32,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [3:0]        st_be,
  input  logic [31:0]       st_data,
  input  logic              bar_req,
  output logic              bar_done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_strb,
  output logic [31:0]       mem_data
);
  localparam int LANES  = 4;
  localparam int WORD_W = ADDR_W - 2;
  localparam int TMR_W  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  logic [WORD_W-1:0] ent_word, n_word;
  logic [31:0]       ent_data, n_data;
  logic [3:0]        ent_mask, n_mask;
  logic [TMR_W-1:0]  ent_tmr, n_tmr;
  logic              n_ov;
  logic [ADDR_W-1:0] n_oaddr;
  logic [3:0]        n_ostrb;
  logic [31:0]       n_odata;

  logic [WORD_W-1:0] st_word;
  logic [31:0]       mrg_data, new_data;
  logic              out_free, acc, held, hit, miss, expired;

  assign st_word  = st_addr[ADDR_W-1:2];
  assign out_free = !mem_valid || mem_ready;
  assign st_ready = out_free && !bar_req;
  assign acc      = st_valid && st_ready;
  assign held     = ent_mask != 4'h0;
  assign hit      = held && (ent_word == st_word);
  assign miss     = held && !hit;
  assign expired  = held && (ent_tmr == TMR_LAST);
  assign bar_done = bar_req && !held && !mem_valid;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mrg_data[8*i +: 8] = st_be[i] ? st_data[8*i +: 8] : ent_data[8*i +: 8];
    assign new_data[8*i +: 8] = st_be[i] ? st_data[8*i +: 8] : 8'h00;
  end

  always_comb begin
    n_word  = ent_word;
    n_data  = ent_data;
    n_mask  = ent_mask;
    n_tmr   = (held && ent_tmr != TMR_LAST) ? ent_tmr + 1'b1 : ent_tmr;
    n_ov    = mem_valid;
    n_oaddr = mem_addr;
    n_ostrb = mem_strb;
    n_odata = mem_data;
    if (out_free) begin
      n_ov = 1'b0;
      if (acc && miss) begin
        n_ov    = 1'b1;
        n_oaddr = {ent_word, 2'b00};
        n_ostrb = ent_mask;
        n_odata = ent_data;
        n_word  = st_word;
        n_data  = new_data;
        n_mask  = st_be;
        n_tmr   = '0;
      end else begin
        if (acc) begin
          n_word = st_word;
          n_data = mrg_data;
          n_mask = ent_mask | st_be;
          if (!held) n_tmr = '0;
        end
        if (n_mask != 4'h0 && (n_mask == 4'hF || bar_req || expired)) begin
          n_ov    = 1'b1;
          n_oaddr = {n_word, 2'b00};
          n_ostrb = n_mask;
          n_odata = n_data;
          n_mask  = 4'h0;
          n_tmr   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_word  <= '0;
      ent_data  <= '0;
      ent_mask  <= '0;
      ent_tmr   <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_strb  <= '0;
      mem_data  <= '0;
    end else begin
      ent_word  <= n_word;
      ent_data  <= n_data;
      ent_mask  <= n_mask;
      ent_tmr   <= n_tmr;
      mem_valid <= n_ov;
      mem_addr  <= n_oaddr;
      mem_strb  <= n_ostrb;
      mem_data  <= n_odata;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_strb)); // R9
  AST_STROBE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_strb != 4'h0); // R2
  AST_BARRIER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    bar_req && held && out_free |=> mem_valid && mem_strb == $past(ent_mask)); // R7
  AST_FULL_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !miss && ((ent_mask | st_be) == 4'hF) |=> mem_valid && mem_strb == 4'hF); // R3
  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !held |=> (ent_mask == 4'h0) || (ent_tmr == '0)); // R4
endmodule

// File: tb/store_merge_buf_test.sv
module store_merge_buf_test;
  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, bar_req = 1'b0, mem_ready = 1'b1;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [3:0]  st_be = '0;
  logic st_ready, bar_done, mem_valid;
  logic [31:0] mem_addr, mem_data;
  logic [3:0]  mem_strb;

  always #5 clk = ~clk;

  store_merge_buf #(.ADDR_W(32), .TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_be(st_be), .st_data(st_data), .bar_req(bar_req),
    .bar_done(bar_done), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_strb(mem_strb), .mem_data(mem_data));

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  logic [29:0] mw = '0;
  logic [31:0] md = '0;
  logic [3:0]  mo = '0;
  int          age = 0;
  bit          ov = 0;
  logic [31:0] oaddr = '0, odata = '0;
  logic [3:0]  ostrb = '0;
  bit          last_acc, last_done;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    bit p_ready, p_done, free, acc, had, opened;
    int a0;
    logic [31:0] lm;
    #1;
    p_ready = (!ov || mem_ready) && !bar_req;
    p_done  = bar_req && (mo == 0) && !ov;
    chk(st_ready === p_ready, tag, "st_ready", 32'(st_ready), 32'(p_ready));
    chk(bar_done === p_done, tag, "bar_done", 32'(bar_done), 32'(p_done));
    chk(mem_valid === ov, tag, "mem_valid", 32'(mem_valid), 32'(ov));
    if (ov) begin
      for (int i = 0; i < 4; i++) lm[8*i +: 8] = ostrb[i] ? 8'hFF : 8'h00;
      chk(mem_addr === oaddr, tag, "mem_addr", mem_addr, oaddr);
      chk(mem_strb === ostrb, tag, "mem_strb", 32'(mem_strb), 32'(ostrb));
      chk((mem_data & lm) === (odata & lm), tag, "mem_data", mem_data & lm, odata & lm);
    end
    last_acc  = st_valid && p_ready;
    last_done = p_done;
    free = !ov || mem_ready;
    acc  = last_acc;
    @(posedge clk);
    if (!free) begin
      if (mo != 0) age++;
    end else begin
      ov = 0;
      if (acc && mo != 0 && st_addr[31:2] != mw) begin
        ov = 1; oaddr = {mw, 2'b00}; odata = md; ostrb = mo;
        mw = st_addr[31:2]; mo = st_be; md = st_data; age = 0;
      end else begin
        had = (mo != 0); a0 = age; opened = 0;
        if (acc) begin
          if (!had) begin mw = st_addr[31:2]; age = 0; opened = 1; end
          for (int i = 0; i < 4; i++)
            if (st_be[i]) begin md[8*i +: 8] = st_data[8*i +: 8]; mo[i] = 1'b1; end
        end
        if (mo != 0 && (mo == 4'hF || bar_req || (had && a0 >= TMO - 1))) begin
          ov = 1; oaddr = {mw, 2'b00}; odata = md; ostrb = mo; mo = 0; age = 0;
        end else if (mo != 0 && !opened) age++;
      end
    end
    @(negedge clk);
  endtask

  task automatic store(input logic [31:0] a, input logic [3:0] be,
                       input logic [31:0] d, input string tag);
    st_valid = 1; st_addr = a; st_be = be; st_data = d;
    do tick(tag); while (!last_acc);
    st_valid = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic barrier(input string tag);
    bar_req = 1;
    do tick(tag); while (!last_done);
    bar_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(mem_valid === 1'b0, "R1", "reset mem_valid", 32'(mem_valid), 0);
    chk(st_ready === 1'b1, "R1", "reset st_ready", 32'(st_ready), 1);
    @(negedge clk);
    idle(2, "R1");

    store(32'h100, 4'b0001, 32'h000000A1, "R2");
    store(32'h103, 4'b0010, 32'h0000B200, "R2");
    barrier("R2");
    idle(2, "R2");

    store(32'h200, 4'b0001, 32'h000000C0, "R3");
    store(32'h200, 4'b0010, 32'h0000C100, "R3");
    store(32'h200, 4'b0100, 32'h00C20000, "R3");
    store(32'h200, 4'b1000, 32'hC3000000, "R3");
    idle(3, "R3");

    store(32'h300, 4'b0001, 32'h000000D0, "R10");
    store(32'h300, 4'b0100, 32'h00D20000, "R10");
    store(32'h300, 4'b0010, 32'h0000D100, "R10");
    store(32'h300, 4'b1000, 32'hD3000000, "R10");
    idle(3, "R10");

    store(32'h400, 4'b0100, 32'h00E00000, "R4");
    idle(3, "R4");
    store(32'h400, 4'b0001, 32'h000000E1, "R4");
    idle(TMO + 4, "R4");

    store(32'h500, 4'b0010, 32'h00001100, "R5");
    idle(2, "R5");
    store(32'h500, 4'b0010, 32'h00002200, "R5");
    idle(TMO + 3, "R5");

    store(32'h600, 4'b0011, 32'h00004321, "R6");
    store(32'h700, 4'b0100, 32'h00550000, "R6");
    idle(2, "R6");
    barrier("R6");

    store(32'h800, 4'b1000, 32'h77000000, "R7");
    mem_ready = 0;
    bar_req = 1;
    idle(4, "R9");
    mem_ready = 1;
    do tick("R8"); while (!last_done);
    bar_req = 0;
    idle(1, "R8");
    barrier("R8");

    mem_ready = 0;
    store(32'h900, 4'hF, 32'h89ABCDEF, "R9");
    st_valid = 1; st_addr = 32'hA00; st_be = 4'b0001; st_data = 32'h5A;
    idle(4, "R9");
    mem_ready = 1;
    do tick("R9"); while (!last_acc);
    st_valid = 0;
    idle(TMO + 3, "R9");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule